// File: doc/BRIEF.md
# Runahead Load Source Arbiter

This block settles where a speculative load gets its value when it looks up three structures at the same time: a small store buffer, a runahead forwarding cache that holds the results of stores that have already left the window, and the first-level data cache. It resolves the three results in a fixed priority order. Alongside the data it reports whether the destination register has to be marked invalid. When nothing hits, it asks the second-level cache for the line.

The block holds the per-entry invalid bits of the store buffer. Stores that finish execution with valid data clear their bit. Stores scheduled with invalid operands set it. A valid store that misses the data cache also raises a prefetch request. The second-level response comes back through the block. A hit there completes the load normally. A miss while the core is running ahead completes the load as invalid and pulls it out of the scheduler, but the memory request still goes out. All outputs are registered and appear one clock after the inputs that cause them. The cache arrays themselves live outside the block.

Top module: `runahead_ld_arbiter`

## Requirements
- R1: A lookup (`ld_valid`=1) with `ld_src_inv`=1 produces, one cycle later, `res_valid`=1, `res_inv`=1, `res_src`=0 (none) and `res_data`=0, and raises no `l2_req`, whatever the lookup results are.
- R2: Among the sources, a store-buffer match takes precedence over a runahead-cache hit, and a runahead-cache hit takes precedence over a data-cache hit. `res_src` encodes the source as 1 = store buffer, 2 = runahead cache, 3 = data cache, 4 = second level.
- R3: On a store-buffer match, the selected entry supplies its slice `sb_data[i*DATA_W +: DATA_W]` with `res_inv`=0 if its invalid bit is clear. If the bit is set, `res_inv`=1 and `res_data`=0.
- R4: When several entries match, the youngest store older than the load wins. Candidates are scanned from entry `ld_sb_pos`-1 downward, modulo `SB_DEPTH`, and the first match in that scan is selected.
- R5: A runahead-cache hit with no store-buffer match returns `rc_data` with `res_inv`=0 only when every bit of `rc_byte_inv` is zero. Otherwise it gives `res_inv`=1 and `res_data`=0.
- R6: A load that hits only the data cache returns `dc_data` with `res_inv`=0.
- R7: A load that misses all three sources pulses `l2_req` for one cycle, one cycle later, and produces no `res_valid`.
- R8: A second-level response with `l2_hit`=1 gives `res_valid`=1, `res_src`=4, `res_inv`=0 and `res_data`=`l2_data` one cycle later.
- R9: A second-level response with `l2_hit`=0 always pulses `mem_req`. With `ra_mode`=1 it also gives `res_valid`=1, `res_inv`=1, `sched_remove`=1 and `res_src`=4. With `ra_mode`=0 it gives no `res_valid` and no `sched_remove`.
- R10: All store-buffer invalid bits are clear after reset. `st_sched_inv` sets the bit of entry `st_idx`, `st_done_ok` clears it, and lookups see the bit as it stood before the current clock edge.
- R11: `st_done_ok`=1 together with `st_dc_miss`=1 pulses `pf_req` one cycle later. A store that hits the data cache, or an invalid store, raises none.
- R12: In a cycle after no lookup, response or store event, `res_valid`, `l2_req`, `mem_req`, `sched_remove` and `pf_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ra_mode | input | 1 | Core is in runahead mode |
| ld_valid | input | 1 | A load lookup is presented this cycle |
| ld_src_inv | input | 1 | The load's address source register is invalid |
| ld_sb_pos | input | IDX_W | Store-buffer slot just after the load in age order |
| sb_match | input | SB_DEPTH | Per-entry address match, older stores only |
| sb_data | input | SB_DEPTH*DATA_W | Store-buffer entry data, entry i at bits i*DATA_W |
| rc_hit | input | 1 | Runahead cache hit |
| rc_byte_inv | input | DATA_W/8 | Invalid bits of the accessed runahead-cache bytes |
| rc_data | input | DATA_W | Runahead cache data |
| dc_hit | input | 1 | Data cache hit |
| dc_data | input | DATA_W | Data cache data |
| l2_rsp_valid | input | 1 | Second-level response present |
| l2_hit | input | 1 | Second-level response was a hit |
| l2_data | input | DATA_W | Second-level fill data |
| st_done_ok | input | 1 | A valid store completed execution |
| st_sched_inv | input | 1 | An invalid store was scheduled |
| st_idx | input | IDX_W | Store-buffer entry of the store event |
| st_dc_miss | input | 1 | The completing store missed the data cache |
| res_valid | output | 1 | Load result is available |
| res_src | output | 3 | Source code of the result |
| res_data | output | DATA_W | Result data |
| res_inv | output | 1 | Destination must be marked invalid |
| l2_req | output | 1 | Second-level request pulse |
| mem_req | output | 1 | Memory request pulse after a second-level miss |
| sched_remove | output | 1 | Remove the load from the scheduler |
| pf_req | output | 1 | Prefetch request pulse for a store |

## Verification
The bench builds the block with its defaults: four store-buffer entries and a 32-bit data path. Four entries are few enough that random match vectors often carry two or more matches, so the youngest-older scan and its wrap past entry zero come up many times. A random entry index also often lands on an entry whose invalid bit an earlier store event set or cleared. The four-byte invalid vector is small enough that random values reach both the all-clear case and the partially-invalid case of the runahead cache.

// File: rtl/ra_ld_pkg.sv
package ra_ld_pkg;
  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_SB   = 3'd1,
    SRC_RC   = 3'd2,
    SRC_DC   = 3'd3,
    SRC_L2   = 3'd4
  } ld_src_e;

  typedef struct packed {
    logic    valid;
    ld_src_e src;
    logic    inv;
    logic    l2_req;
    logic    mem_req;
    logic    remove;
  } ld_res_t;
endpackage

// File: rtl/sb_inv_bank.sv
module sb_inv_bank #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 32,
  localparam int IW    = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                set_en,
  input  logic                clr_en,
  input  logic [IW-1:0]       upd_idx,
  input  logic [IW-1:0]       ld_pos,
  input  logic [DEPTH-1:0]    match,
  input  logic [DEPTH*DATA_W-1:0] data_flat,
  output logic                any_hit,
  output logic                hit_inv,
  output logic [DATA_W-1:0]   hit_data
);
  logic [DEPTH-1:0] inv_q, inv_d;
  logic             upd_en;
  logic [IW-1:0]    sel;

  // next-state of the invalid bits
  always_comb begin
    inv_d = inv_q;
    if (set_en) inv_d[upd_idx] = 1'b1;
    if (clr_en) inv_d[upd_idx] = 1'b0;
  end

  assign upd_en = set_en | clr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      inv_q <= '0;
    else if (upd_en) inv_q <= inv_d;
  end

  // youngest older match: scan downward from the load position
  always_comb begin
    logic [IW-1:0] idx;
    any_hit = 1'b0;
    sel     = '0;
    for (int k = 1; k <= DEPTH; k++) begin
      idx = IW'(ld_pos - IW'(k));
      if (!any_hit && match[idx]) begin
        any_hit = 1'b1;
        sel     = idx;
      end
    end
  end

  assign hit_inv  = inv_q[sel];
  assign hit_data = data_flat[sel*DATA_W +: DATA_W];
endmodule

// File: rtl/ld_resolve.sv
module ld_resolve
  import ra_ld_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int NB    = DATA_W / 8
) (
  input  logic              ra_mode,
  input  logic              ld_valid,
  input  logic              ld_src_inv,
  input  logic              sb_any,
  input  logic              sb_inv,
  input  logic [DATA_W-1:0] sb_val,
  input  logic              rc_hit,
  input  logic [NB-1:0]     rc_byte_inv,
  input  logic [DATA_W-1:0] rc_data,
  input  logic              dc_hit,
  input  logic [DATA_W-1:0] dc_data,
  input  logic              l2_rsp_valid,
  input  logic              l2_hit,
  input  logic [DATA_W-1:0] l2_data,
  output ld_res_t           res,
  output logic [DATA_W-1:0] data
);
  always_comb begin
    res  = '0;
    data = '0;
    if (ld_valid) begin
      if (ld_src_inv) begin
        res.valid = 1'b1;
        res.inv   = 1'b1;
        res.src   = SRC_NONE;
      end else if (sb_any) begin
        res.valid = 1'b1;
        res.src   = SRC_SB;
        res.inv   = sb_inv;
        data      = sb_inv ? '0 : sb_val;
      end else if (rc_hit) begin
        res.valid = 1'b1;
        res.src   = SRC_RC;
        res.inv   = |rc_byte_inv;
        data      = (|rc_byte_inv) ? '0 : rc_data;
      end else if (dc_hit) begin
        res.valid = 1'b1;
        res.src   = SRC_DC;
        data      = dc_data;
      end else begin
        res.l2_req = 1'b1;
      end
    end else if (l2_rsp_valid) begin
      res.src = SRC_L2;
      if (l2_hit) begin
        res.valid = 1'b1;
        data      = l2_data;
      end else begin
        res.mem_req = 1'b1;
        if (ra_mode) begin
          res.valid  = 1'b1;
          res.inv    = 1'b1;
          res.remove = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/runahead_ld_arbiter.sv
module runahead_ld_arbiter
  import ra_ld_pkg::*;
#(
  parameter int SB_DEPTH = 4,
  parameter int DATA_W   = 32,
  localparam int IDX_W   = $clog2(SB_DEPTH),
  localparam int NB      = DATA_W / 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ra_mode,
  input  logic                       ld_valid,
  input  logic                       ld_src_inv,
  input  logic [IDX_W-1:0]           ld_sb_pos,
  input  logic [SB_DEPTH-1:0]        sb_match,
  input  logic [SB_DEPTH*DATA_W-1:0] sb_data,
  input  logic                       rc_hit,
  input  logic [NB-1:0]              rc_byte_inv,
  input  logic [DATA_W-1:0]          rc_data,
  input  logic                       dc_hit,
  input  logic [DATA_W-1:0]          dc_data,
  input  logic                       l2_rsp_valid,
  input  logic                       l2_hit,
  input  logic [DATA_W-1:0]          l2_data,
  input  logic                       st_done_ok,
  input  logic                       st_sched_inv,
  input  logic [IDX_W-1:0]           st_idx,
  input  logic                       st_dc_miss,
  output logic                       res_valid,
  output logic [2:0]                 res_src,
  output logic [DATA_W-1:0]          res_data,
  output logic                       res_inv,
  output logic                       l2_req,
  output logic                       mem_req,
  output logic                       sched_remove,
  output logic                       pf_req
);
  logic              sb_any, sb_inv;
  logic [DATA_W-1:0] sb_val;
  ld_res_t           res_d, res_q;
  logic [DATA_W-1:0] data_d, data_q;
  logic              pf_d, pf_q;

  sb_inv_bank #(.DEPTH(SB_DEPTH), .DATA_W(DATA_W)) sb_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_en    (st_sched_inv),
    .clr_en    (st_done_ok),
    .upd_idx   (st_idx),
    .ld_pos    (ld_sb_pos),
    .match     (sb_match),
    .data_flat (sb_data),
    .any_hit   (sb_any),
    .hit_inv   (sb_inv),
    .hit_data  (sb_val)
  );

  ld_resolve #(.DATA_W(DATA_W)) rs_i (
    .ra_mode      (ra_mode),
    .ld_valid     (ld_valid),
    .ld_src_inv   (ld_src_inv),
    .sb_any       (sb_any),
    .sb_inv       (sb_inv),
    .sb_val       (sb_val),
    .rc_hit       (rc_hit),
    .rc_byte_inv  (rc_byte_inv),
    .rc_data      (rc_data),
    .dc_hit       (dc_hit),
    .dc_data      (dc_data),
    .l2_rsp_valid (l2_rsp_valid),
    .l2_hit       (l2_hit),
    .l2_data      (l2_data),
    .res          (res_d),
    .data         (data_d)
  );

  assign pf_d = st_done_ok & st_dc_miss;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      pf_q  <= 1'b0;
    end else begin
      res_q <= res_d;
      pf_q  <= pf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           data_q <= '0;
    else if (res_d.valid) data_q <= data_d;
  end

  assign res_valid    = res_q.valid;
  assign res_src      = res_q.src;
  assign res_inv      = res_q.inv;
  assign l2_req       = res_q.l2_req;
  assign mem_req      = res_q.mem_req;
  assign sched_remove = res_q.remove;
  assign res_data     = data_q;
  assign pf_req       = pf_q;
endmodule

// File: rtl/ra_ld_arb_chk.sv
module ra_ld_arb_chk #(
  parameter int SB_DEPTH = 4,
  parameter int DATA_W   = 32,
  localparam int IDX_W   = $clog2(SB_DEPTH),
  localparam int NB      = DATA_W / 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       ra_mode,
  input logic                       ld_valid,
  input logic                       ld_src_inv,
  input logic [IDX_W-1:0]           ld_sb_pos,
  input logic [SB_DEPTH-1:0]        sb_match,
  input logic [SB_DEPTH*DATA_W-1:0] sb_data,
  input logic                       rc_hit,
  input logic [NB-1:0]              rc_byte_inv,
  input logic [DATA_W-1:0]          rc_data,
  input logic                       dc_hit,
  input logic [DATA_W-1:0]          dc_data,
  input logic                       l2_rsp_valid,
  input logic                       l2_hit,
  input logic [DATA_W-1:0]          l2_data,
  input logic                       st_done_ok,
  input logic                       st_sched_inv,
  input logic [IDX_W-1:0]           st_idx,
  input logic                       st_dc_miss,
  input logic                       res_valid,
  input logic [2:0]                 res_src,
  input logic [DATA_W-1:0]          res_data,
  input logic                       res_inv,
  input logic                       l2_req,
  input logic                       mem_req,
  input logic                       sched_remove,
  input logic                       pf_req
);
  assert_src_inv_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && ld_src_inv |=> res_valid && res_inv && !l2_req && res_src == 3'd0);

  assert_sb_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && !ld_src_inv && (|sb_match) |=> res_valid && res_src == 3'd1);

  assert_rc_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && !ld_src_inv && !(|sb_match) && rc_hit && rc_byte_inv == '0
    |=> res_valid && !res_inv && res_data == $past(rc_data));

  assert_dc_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && !ld_src_inv && !(|sb_match) && !rc_hit && dc_hit
    |=> res_valid && !res_inv && res_src == 3'd3 && res_data == $past(dc_data));

  assert_all_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && !ld_src_inv && !(|sb_match) && !rc_hit && !dc_hit
    |=> l2_req && !res_valid);

  assert_l2_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid && l2_rsp_valid && l2_hit |=> res_valid && !res_inv && res_data == $past(l2_data));

  assert_l2_miss_ra_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid && l2_rsp_valid && !l2_hit && ra_mode |=> mem_req && sched_remove && res_inv);

  assert_remove_inv_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sched_remove |-> res_inv && res_valid);

  assert_prefetch_R11: assert property (@(posedge clk) disable iff (!rst_n)
    st_done_ok && st_dc_miss |=> pf_req);

  assert_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid && !l2_rsp_valid && !st_done_ok
    |=> !res_valid && !l2_req && !mem_req && !pf_req);
endmodule

bind runahead_ld_arbiter ra_ld_arb_chk #(.SB_DEPTH(SB_DEPTH), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/runahead_ld_arbiter_tb_top.sv
module runahead_ld_arbiter_tb_top;
  localparam int N  = 4;
  localparam int W  = 32;
  localparam int IW = 2;
  localparam int NB = 4;

  logic clk, rst_n, ra_mode, ld_valid, ld_src_inv;
  logic [IW-1:0] ld_sb_pos, st_idx;
  logic [N-1:0] sb_match;
  logic [N*W-1:0] sb_data;
  logic rc_hit, dc_hit, l2_rsp_valid, l2_hit, st_done_ok, st_sched_inv, st_dc_miss;
  logic [NB-1:0] rc_byte_inv;
  logic [W-1:0] rc_data, dc_data, l2_data, res_data;
  logic res_valid, res_inv, l2_req, mem_req, sched_remove, pf_req;
  logic [2:0] res_src;

  int tests = 0, fails = 0;
  logic [N-1:0] m_inv;
  logic e_valid, e_inv, e_l2, e_mem, e_rem, e_pf;
  logic [2:0] e_src;
  logic [W-1:0] e_data;

  runahead_ld_arbiter dut_i (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic idle_inputs();
    ld_valid = 0; ld_src_inv = 0; ld_sb_pos = '0; sb_match = '0; sb_data = '0;
    rc_hit = 0; rc_byte_inv = '0; rc_data = '0; dc_hit = 0; dc_data = '0;
    l2_rsp_valid = 0; l2_hit = 0; l2_data = '0;
    st_done_ok = 0; st_sched_inv = 0; st_idx = '0; st_dc_miss = 0;
  endtask

  task automatic clear_exp();
    e_valid = 0; e_inv = 0; e_l2 = 0; e_mem = 0; e_rem = 0; e_pf = 0;
    e_src = 3'd0; e_data = '0;
  endtask

  // expected result of the lookup on the current inputs, from the requirements
  task automatic model_lookup();
    logic found;
    logic [IW-1:0] idx, sel;
    clear_exp();
    found = 0; sel = '0;
    for (int k = 1; k <= N; k++) begin
      idx = IW'(ld_sb_pos - IW'(k));
      if (!found && sb_match[idx]) begin found = 1; sel = idx; end
    end
    if (ld_src_inv) begin e_valid = 1; e_inv = 1; e_src = 3'd0; end
    else if (found) begin
      e_valid = 1; e_src = 3'd1; e_inv = m_inv[sel];
      e_data = m_inv[sel] ? '0 : sb_data[sel*W +: W];
    end else if (rc_hit) begin
      e_valid = 1; e_src = 3'd2; e_inv = |rc_byte_inv;
      e_data = (|rc_byte_inv) ? '0 : rc_data;
    end else if (dc_hit) begin
      e_valid = 1; e_src = 3'd3; e_data = dc_data;
    end else e_l2 = 1;
  endtask

  task automatic model_l2();
    clear_exp();
    e_src = 3'd4;
    if (l2_hit) begin e_valid = 1; e_data = l2_data; end
    else begin
      e_mem = 1;
      if (ra_mode) begin e_valid = 1; e_inv = 1; e_rem = 1; end
    end
    if (!e_valid) e_src = 3'd0;
  endtask

  // inputs already driven at a negedge; wait one edge, compare at next negedge
  task automatic step_check(input string tag);
    logic [8:0] act, exp;
    @(negedge clk);
    act = {res_valid, res_src, res_inv, l2_req, mem_req, sched_remove, pf_req};
    exp = {e_valid, e_src, e_inv, e_l2, e_mem, e_rem, e_pf};
    if (!e_valid) begin act[7:5] = 3'd0; exp[7:5] = 3'd0; end
    tests++;
    if (act !== exp || (e_valid && res_data !== e_data)) begin
      fails++;
      $display("FAIL %s: flags act=%b exp=%b data act=%h exp=%h", tag, act, exp, res_data, e_data);
    end
    if (st_sched_inv) m_inv[st_idx] = 1'b1;
    if (st_done_ok)   m_inv[st_idx] = 1'b0;
    idle_inputs();
  endtask

  task automatic rand_sb();
    for (int i = 0; i < N; i++) sb_data[i*W +: W] = $urandom;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    idle_inputs(); ra_mode = 1; m_inv = '0; clear_exp();
    rst_n = 0;
    repeat (3) @(negedge clk);
    tests++;
    if (res_valid !== 0 || l2_req !== 0 || mem_req !== 0 || sched_remove !== 0 || pf_req !== 0) begin
      fails++; $display("FAIL R12 reset: outputs act=%b exp=0", {res_valid, l2_req, mem_req, sched_remove, pf_req});
    end
    rst_n = 1;
    @(negedge clk);

    // R10: all bits clear after reset -> hit on entry 2 is valid
    rand_sb(); ld_valid = 1; sb_match = 4'b0100; ld_sb_pos = 2'd3; model_lookup(); step_check("R10 reset clear");
    // R1 with every source hitting
    rand_sb(); ld_valid = 1; ld_src_inv = 1; sb_match = 4'b1111; rc_hit = 1; dc_hit = 1; model_lookup(); step_check("R1 src inv");
    // R10: invalid store sets entry 2
    st_sched_inv = 1; st_idx = 2'd2; clear_exp(); step_check("R10 set");
    rand_sb(); ld_valid = 1; sb_match = 4'b0100; ld_sb_pos = 2'd3; model_lookup(); step_check("R3 inv entry");
    // R10/R11: valid store clears entry 2, missing the data cache
    st_done_ok = 1; st_idx = 2'd2; st_dc_miss = 1; clear_exp(); e_pf = 1; step_check("R11 prefetch");
    rand_sb(); ld_valid = 1; sb_match = 4'b0100; ld_sb_pos = 2'd3; model_lookup(); step_check("R10 clear");
    // R11: store hitting the data cache gives no prefetch
    st_done_ok = 1; st_idx = 2'd1; clear_exp(); step_check("R11 no prefetch");
    // R4: wrap, pos=1 with matches 0 and 3 -> entry 0; matches 2,3 -> entry 3
    rand_sb(); ld_valid = 1; ld_sb_pos = 2'd1; sb_match = 4'b1001; model_lookup(); step_check("R4 wrap a");
    rand_sb(); ld_valid = 1; ld_sb_pos = 2'd1; sb_match = 4'b1100; model_lookup(); step_check("R4 wrap b");
    // R2: rc over dc; R5 partial invalid
    ld_valid = 1; rc_hit = 1; rc_data = 32'hCAFE_0001; dc_hit = 1; dc_data = 32'h1111_2222; model_lookup(); step_check("R2 rc over dc");
    ld_valid = 1; rc_hit = 1; rc_byte_inv = 4'b0010; rc_data = 32'hCAFE_0002; model_lookup(); step_check("R5 byte inv");
    ld_valid = 1; dc_hit = 1; dc_data = 32'hD00D_F00D; model_lookup(); step_check("R6 dc only");
    ld_valid = 1; model_lookup(); step_check("R7 all miss");
    l2_rsp_valid = 1; l2_hit = 1; l2_data = 32'hABCD_0123; model_l2(); step_check("R8 l2 hit");
    ra_mode = 1; l2_rsp_valid = 1; model_l2(); step_check("R9 l2 miss runahead");
    ra_mode = 0; l2_rsp_valid = 1; model_l2(); step_check("R9 l2 miss normal");
    clear_exp(); step_check("R12 idle");

    // constrained random mix
    for (int it = 0; it < 600; it++) begin
      int op;
      op = $urandom_range(0, 9);
      ra_mode = $urandom_range(0, 1);
      if (op <= 4) begin
        rand_sb();
        ld_valid = 1;
        ld_src_inv = ($urandom_range(0, 7) == 0);
        ld_sb_pos = IW'($urandom);
        sb_match = ($urandom_range(0, 2) == 0) ? N'($urandom) : '0;
        rc_hit = $urandom_range(0, 1);
        rc_byte_inv = ($urandom_range(0, 1) == 0) ? '0 : NB'($urandom);
        rc_data = $urandom; dc_hit = $urandom_range(0, 1); dc_data = $urandom;
        model_lookup(); step_check("R2 R3 R4 R5 R6 R7 random lookup");
      end else if (op <= 6) begin
        l2_rsp_valid = 1; l2_hit = $urandom_range(0, 1); l2_data = $urandom;
        model_l2(); step_check("R8 R9 random l2");
      end else if (op == 7) begin
        st_done_ok = 1; st_idx = IW'($urandom); st_dc_miss = $urandom_range(0, 1);
        clear_exp(); e_pf = st_dc_miss; step_check("R10 R11 random store done");
      end else if (op == 8) begin
        st_sched_inv = 1; st_idx = IW'($urandom);
        clear_exp(); step_check("R10 random store inv");
      end else begin
        clear_exp(); step_check("R12 random idle");
      end
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule